// File: doc/BRIEF.md
# Shared Special-Operation Issue Unit

This block sits next to an 8-lane arithmetic core and runs one instruction for a 32-thread group. The group is handled in four slices of 8 threads, and two half-width execution engines share each slice: engine 0 takes lanes 0 to 3 and engine 1 takes lanes 4 to 7. The requester presents an opcode, a 32-bit active mask and 32 operand pairs with a valid strobe. When the unit is ready it captures them, works through the slices, and returns 32 results together with a one-cycle done pulse.

Every operation class completes after its own fixed latency, whatever the mask holds. An integer multiply takes 4 cycles. A single special step returns an integer reciprocal estimate and takes 16 cycles. A chained operation runs two special steps back to back and takes 32 cycles. Only one instruction is in flight at a time. Ready is low from the cycle after an issue is captured until the done pulse, and ready rises in the same cycle as done, so the next issue can be captured at the edge that ends the done cycle.

Top module: `sop_issue_unit`

## Requirements
- R1: After synchronous reset, `ready` is 1, `done` is 0 and all of `result` is 0.
- R2: An issue is captured at a rising edge where `issue_valid` and `ready` are both 1. From the next cycle `ready` is 0 until the done pulse.
- R3: `done` is high for exactly one cycle per captured issue, and `ready` is 1 in that cycle. While `ready` is 0, `issue_valid` and changes on the opcode, mask and operand inputs have no effect on the running instruction or its results.
- R4: Opcode 0 (multiply) raises `done` 4 cycles after the capturing edge.
- R5: Opcode 1 (special step) raises `done` 16 cycles after the capturing edge.
- R6: Opcodes 2 and 3 (chained step) raise `done` 32 cycles after the capturing edge.
- R7: For opcode 0, thread t returns the low 32 bits of a[t] * b[t].
- R8: For opcode 1, thread t returns floor((2^32-1)/a[t]) for nonzero a[t] and 0xFFFFFFFF for a[t]=0. Operand b is ignored.
- R9: For opcodes 2 and 3, thread t returns R8's function applied twice to a[t].
- R10: A thread whose bit t in `active_mask` is 0 returns 0. The mask does not change the latency, and an all-zero mask still produces a done pulse.
- R11: `result` holds its value from the done pulse until the next issue is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request strobe |
| opcode | input | 2 | 0 multiply, 1 special step, 2 or 3 chained step |
| active_mask | input | 32 | Bit t enables thread t |
| opnd_a | input | 1024 | Operand a, thread t in bits [32t+31:32t] |
| opnd_b | input | 1024 | Operand b, same packing |
| ready | output | 1 | Unit can capture an issue |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1024 | Per-thread results, same packing |

## Verification
The assertions assume that the requester treats `issue_valid` as a request that can only be taken while `ready` is high. They also assume that nothing reaches the latency or stability checks except through a captured issue. The bench waits for `ready` before each issue and often issues on the done cycle, which covers back-to-back capture. To check R3, it also drives a deliberate request with changed operands while the unit is busy and withdraws it before ready returns. Operand patterns mix random values with zero, one, all ones and the top bit alone, under full, partial and empty masks.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    OPC_MUL   = 2'd0,
    OPC_SPC   = 2'd1,
    OPC_CHN   = 2'd2,
    OPC_CHN_B = 2'd3
  } sop_opc_e;

  // Chained forms are recognised by the upper opcode bit alone.
  function automatic logic is_chain(input logic [1:0] opc);
    return opc[1];
  endfunction
endpackage

// File: rtl/sop_engine.sv
// One half-width engine: NL lanes evaluated in the same cycle.
module sop_engine #(
  parameter int W  = 32,
  parameter int NL = 4
) (
  input  logic          do_mul,
  input  logic [NL*W-1:0] a_in,
  input  logic [NL*W-1:0] b_in,
  output logic [NL*W-1:0] y_out
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [W-1:0]   a, b, rcp;
    logic [2*W-1:0] prod;
    assign a    = a_in[l*W +: W];
    assign b    = b_in[l*W +: W];
    assign prod = a * b;
    assign rcp  = (a == '0) ? ALL1 : (ALL1 / a);
    assign y_out[l*W +: W] = do_mul ? prod[W-1:0] : rcp;
  end
endmodule

// File: rtl/sop_seq.sv
// Latency sequencer: counts the fixed latency of each class and marks
// the cycles in which slices are processed.
module sop_seq #(
  parameter int SLICES  = 4,
  parameter int LAT_MUL = 4,
  parameter int LAT_SPC = 16,
  parameter int LAT_CHN = 32,
  localparam int CW = $clog2(LAT_CHN + 1),
  localparam int SW = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    opc,
  output logic          busy,
  output logic          done,
  output logic          pass_en,
  output logic          pass_late,
  output logic [SW-1:0] pass_idx
);
  logic [CW-1:0] cnt, lim;
  logic          chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      lim     <= '0;
      chain_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        cnt     <= '0;
        chain_q <= sop_pkg::is_chain(opc);
        if (sop_pkg::is_chain(opc))            lim <= CW'(LAT_CHN - 1);
        else if (opc == sop_pkg::OPC_SPC)      lim <= CW'(LAT_SPC - 1);
        else                                   lim <= CW'(LAT_MUL - 1);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == lim) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic early, late;
  assign early     = cnt < CW'(SLICES);
  assign late      = chain_q && (cnt >= CW'(LAT_SPC)) && (cnt < CW'(LAT_SPC + SLICES));
  assign pass_en   = busy && (early || late);
  assign pass_late = late;
  assign pass_idx  = early ? cnt[SW-1:0] : SW'(cnt - CW'(LAT_SPC));
endmodule

// File: rtl/sop_issue_unit.sv
module sop_issue_unit #(
  parameter int W       = 32,
  parameter int THREADS = 32,
  parameter int LANES   = 8,
  parameter int UNITS   = 2,
  parameter int LAT_MUL = 4,
  parameter int LAT_SPC = 16,
  parameter int LAT_CHN = 32,
  localparam int UL     = LANES / UNITS,
  localparam int SLICES = THREADS / LANES,
  localparam int SW     = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [1:0]           opcode,
  input  logic [THREADS-1:0]   active_mask,
  input  logic [THREADS*W-1:0] opnd_a,
  input  logic [THREADS*W-1:0] opnd_b,
  output logic                 ready,
  output logic                 done,
  output logic [THREADS*W-1:0] result
);
  logic [W-1:0]       a_q [THREADS];
  logic [W-1:0]       b_q [THREADS];
  logic [W-1:0]       r_q [THREADS];
  logic [THREADS-1:0] mask_q;
  logic [1:0]         opc_q;

  logic          busy, pass_en, pass_late, start;
  logic [SW-1:0] pass_idx;

  assign ready = ~busy;
  assign start = issue_valid & ready;

  sop_seq #(
    .SLICES(SLICES), .LAT_MUL(LAT_MUL), .LAT_SPC(LAT_SPC), .LAT_CHN(LAT_CHN)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .opc(opcode),
    .busy(busy), .done(done), .pass_en(pass_en),
    .pass_late(pass_late), .pass_idx(pass_idx)
  );

  // Engine u serves lanes u*UL .. u*UL+UL-1 of the slice under work.
  logic [UL*W-1:0] eng_a [UNITS];
  logic [UL*W-1:0] eng_b [UNITS];
  logic [UL*W-1:0] eng_y [UNITS];
  logic            is_mul;
  assign is_mul = (opc_q == sop_pkg::OPC_MUL);

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    for (genvar l = 0; l < UL; l++) begin : g_sel
      assign eng_a[u][l*W +: W] = a_q[int'(pass_idx)*LANES + u*UL + l];
      assign eng_b[u][l*W +: W] = b_q[int'(pass_idx)*LANES + u*UL + l];
    end
    sop_engine #(.W(W), .NL(UL)) u_eng (
      .do_mul(is_mul), .a_in(eng_a[u]), .b_in(eng_b[u]), .y_out(eng_y[u])
    );
  end

  logic first_of_chain;
  assign first_of_chain = sop_pkg::is_chain(opc_q) && !pass_late;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      opc_q  <= '0;
      for (int t = 0; t < THREADS; t++) r_q[t] <= '0;
    end else if (start) begin
      mask_q <= active_mask;
      opc_q  <= opcode;
    end else if (pass_en && !first_of_chain) begin
      for (int u = 0; u < UNITS; u++)
        for (int l = 0; l < UL; l++)
          r_q[int'(pass_idx)*LANES + u*UL + l] <=
            mask_q[int'(pass_idx)*LANES + u*UL + l] ? eng_y[u][l*W +: W] : '0;
    end
  end

  // Operand store: loaded on issue, rewritten by the first chained step.
  always_ff @(posedge clk) begin
    if (start) begin
      for (int t = 0; t < THREADS; t++) begin
        a_q[t] <= opnd_a[t*W +: W];
        b_q[t] <= opnd_b[t*W +: W];
      end
    end else if (pass_en && first_of_chain) begin
      for (int u = 0; u < UNITS; u++)
        for (int l = 0; l < UL; l++)
          a_q[int'(pass_idx)*LANES + u*UL + l] <= eng_y[u][l*W +: W];
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_out
    assign result[t*W +: W] = r_q[t];
  end
endmodule

// File: rtl/sop_issue_unit_chk.sv
module sop_issue_unit_chk #(
  parameter int RW      = 1024,
  parameter int LAT_MUL = 4,
  parameter int LAT_SPC = 16,
  parameter int LAT_CHN = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          issue_valid,
  input logic [1:0]    opcode,
  input logic          ready,
  input logic          done,
  input logic [RW-1:0] result
);
  logic       acc;
  logic [7:0] since;
  logic [1:0] op_k;
  int         exp_lat;
  assign acc = issue_valid && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
      op_k  <= '0;
    end else if (acc) begin
      since <= '0;
      op_k  <= opcode;
    end else if (!ready) begin
      since <= since + 1'b1;
    end
  end

  always_comb begin
    if (op_k[1])        exp_lat = LAT_CHN;
    else if (op_k == 1) exp_lat = LAT_SPC;
    else                exp_lat = LAT_MUL;
  end

  AST_BUSY_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    acc |=> !ready) else $error("busy after issue"); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done pulse width"); // R3
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> ready) else $error("ready with done"); // R3
  AST_MUL_LAT: assert property (@(posedge clk) disable iff (rst)
    (done && op_k == 2'd0) |-> (int'(since) == exp_lat)) else $error("mul latency"); // R4
  AST_SPC_LAT: assert property (@(posedge clk) disable iff (rst)
    (done && op_k == 2'd1) |-> (int'(since) == exp_lat)) else $error("special latency"); // R5
  AST_CHN_LAT: assert property (@(posedge clk) disable iff (rst)
    (done && op_k[1]) |-> (int'(since) == exp_lat)) else $error("chain latency"); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(ready) && !$past(acc) && !$past(rst)) |-> $stable(result))
    else $error("result changed while idle"); // R11
endmodule

bind sop_issue_unit sop_issue_unit_chk #(
  .RW(THREADS*W), .LAT_MUL(LAT_MUL), .LAT_SPC(LAT_SPC), .LAT_CHN(LAT_CHN)
) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
  .ready(ready), .done(done), .result(result)
);

// File: tb/tb_sop_issue_unit.sv
module tb_sop_issue_unit;
  localparam int T = 32;
  localparam int W = 32;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           issue_valid = 1'b0;
  logic [1:0]     opcode = '0;
  logic [T-1:0]   active_mask = '0;
  logic [T*W-1:0] opnd_a = '0, opnd_b = '0;
  logic           ready, done;
  logic [T*W-1:0] result;

  sop_issue_unit dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .opcode(opcode),
    .active_mask(active_mask), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ready(ready), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [1:0]     op;
    int             lat;
    int             t0;
    logic [T*W-1:0] res;
  } item_t;

  item_t          sb[$];
  int             cyc = 0;
  int             checks = 0, fails = 0;
  logic [T*W-1:0] last_res = '0;
  bit             finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] ref_rcp(input logic [31:0] x);
    logic [63:0] q;
    if (x == 0) return 32'hFFFF_FFFF;
    q = 64'd4294967295 / {32'd0, x};
    return q[31:0];
  endfunction

  function automatic string rname(input logic [1:0] op);
    if (op == 0) return "R4/R7";
    if (op == 1) return "R5/R8";
    return "R6/R9";
  endfunction

  // Driver: waits for ready, issues, pushes the expected item.
  task automatic issue(input logic [1:0] op, input logic [T-1:0] m, input int pat);
    item_t it;
    logic [63:0] p;
    for (int t = 0; t < T; t++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (pat == 1) begin
        case (t % 5)
          0: a = 32'd0;
          1: a = 32'd1;
          2: a = 32'hFFFF_FFFF;
          3: a = 32'h8000_0000;
          default: a = a >> (t % 29);
        endcase
      end
      opnd_a[t*W +: W] = a;
      opnd_b[t*W +: W] = b;
      p = {32'd0, a} * {32'd0, b};
      if (!m[t])       it.res[t*W +: W] = '0;
      else if (op == 0) it.res[t*W +: W] = p[31:0];
      else if (op == 1) it.res[t*W +: W] = ref_rcp(a);
      else              it.res[t*W +: W] = ref_rcp(ref_rcp(a));
    end
    it.op  = op;
    it.lat = (op == 0) ? 4 : (op == 1) ? 16 : 32;
    @(negedge clk);
    while (!ready) @(negedge clk);
    opcode = op; active_mask = m; issue_valid = 1'b1;
    @(posedge clk);
    #1;
    issue_valid = 1'b0;
    it.t0 = cyc;
    sb.push_back(it);
  endtask

  // R3: a request while busy, with new inputs, must change nothing.
  task automatic poke_busy();
    repeat (2) @(negedge clk);
    opcode = 2'd0; active_mask = '1; opnd_a = {T{32'h1234_5678}};
    opnd_b = {T{32'h0000_0003}}; issue_valid = 1'b1;
    repeat (3) @(negedge clk);
    issue_valid = 1'b0;
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        fails++; checks++;
        $display("FAIL R3: done with no pending issue, actual done=1 expected done=0");
      end else begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (cyc - it.t0 != it.lat) begin
          fails++;
          $display("FAIL %s latency: actual %0d expected %0d", rname(it.op), cyc - it.t0, it.lat);
        end
        checks++;
        if (result !== it.res) begin
          fails++;
          for (int t = 0; t < T; t++)
            if (result[t*W +: W] !== it.res[t*W +: W]) begin
              $display("FAIL %s/R10 thread %0d: actual %h expected %h", rname(it.op), t,
                       result[t*W +: W], it.res[t*W +: W]);
              break;
            end
        end
        last_res = it.res;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (ready !== 1'b1 || done !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1: actual ready=%b done=%b result_nz=%b expected 1 0 0", ready, done, |result);
    end
    issue(2'd0, '1, 0);            // R4 R7 random multiply
    issue(2'd1, '1, 1);            // R5 R8 corner divisors, back-to-back
    poke_busy();                   // R2 R3 ignored request while busy
    issue(2'd2, '1, 1);            // R6 R9 chain
    issue(2'd3, 32'hA5A5_0F0F, 0); // R6 R9 R10 alternate chain code, partial mask
    issue(2'd0, 32'h0000_0000, 0); // R10 empty mask keeps latency
    issue(2'd1, 32'hFFFF_0001, 0); // R8 R10 partial mask
    poke_busy();
    issue(2'd0, 32'h8000_00FF, 1); // R7 corners
    for (int k = 0; k < 6; k++) issue(2'(k % 3), '1, k % 2);
    @(negedge clk);
    while (!ready || sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    checks++;                      // R11 result held while idle
    if (result !== last_res) begin
      fails++;
      $display("FAIL R11: actual result changed expected held value");
    end
    finished = 1;
    summary();
  end
endmodule